// File: doc/BRIEF.md
# BCD Digit Pack and Unpack Unit

This unit converts between a loose decimal form, in which each digit sits in the low nibble of its own byte (for example a pair of ASCII digit characters), and a dense form, in which two digits share one byte. It works on register operands. One operation takes a 32-bit source and a 16-bit adjustment, and merges its result into a copy of a 32-bit destination value. Bits of the destination that the operation does not produce are passed through unchanged.

Densing (pack) adds the adjustment to the low half-word of the source and then keeps two nibbles of the sum. This strips an ASCII bias and can add a constant in the same step. Spreading (unpack) first moves the two nibbles of the source's low byte into separate bytes and then adds the adjustment. This can apply an ASCII bias to both digits at once. No check for valid decimal digits is made: nibble values 0xA to 0xF pass through as they are.

A caller drives the operands and raises the start strobe for one cycle. The result and a one-cycle done strobe appear on the next clock edge. The result then holds until the next start.

Top module: `bcd_xlate`

## Requirements
- R1: While reset is asserted and after it is released, and before any start, `result_o` is 0 and `done_o` is 0.
- R2: `done_o` is high for exactly the cycle after each cycle in which `start_i` is high, and low otherwise. Starts on back-to-back cycles give back-to-back done cycles.
- R3: When `start_i` is low, `result_o` keeps its previous value whatever the other inputs do.
- R4: With `mode_i` = 0 (pack), form s = (src_i[15:0] + adj_i) mod 2^16. Then `result_o[7:0]` = {s[11:8], s[3:0]}, with s[11:8] in bits 7:4.
- R5: In pack mode, `result_o[31:8]` equals `dst_i[31:8]` as sampled at start.
- R6: With `mode_i` = 1 (unpack), form w = {4'h0, src_i[7:4], 4'h0, src_i[3:0]}. Then `result_o[15:0]` = (w + adj_i) mod 2^16.
- R7: In unpack mode, `result_o[31:16]` equals `dst_i[31:16]` as sampled at start.
- R8: The 16-bit addition wraps, and a carry out of bit 15 is dropped in both modes.
- R9: Nibble values 0xA to 0xF are not rejected or corrected. They move exactly as decimal nibbles do.
- R10: In pack mode, `src_i[31:16]` has no effect on `result_o`.
- R11: In unpack mode, `src_i[31:8]` has no effect on `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to perform an operation |
| mode_i | input | 1 | 0 = pack, 1 = unpack |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination value whose untouched bits are preserved |
| adj_i | input | 16 | Adjustment added during the operation |
| result_o | output | 32 | Registered new destination value |
| done_o | output | 1 | One-cycle strobe marking a fresh result |

## Verification
On every cycle the checker confirms that the done strobe follows start by exactly one cycle. It also confirms that the result stays frozen when no start is seen, and that the destination bits outside the written byte or half-word come through from the sampled destination in each mode. The arithmetic of the two conversions is only shown by the bench: the 16-bit wrap, the order of addition relative to nibble movement, the ignored source bits and nibbles above nine. The bench compares the outputs against its own behavioural model on every clock, and also runs directed cases with known answers.

// File: rtl/bcd_xlate_pkg.sv
package bcd_xlate_pkg;

    // Operation select encoding carried on mode_i
    typedef enum logic {
        XL_PACK   = 1'b0,
        XL_UNPACK = 1'b1
    } xl_mode_e;

endpackage

// File: rtl/bcd_pack_path.sv
// Dense path: bias the loose word, then keep the low nibble of each byte.
module bcd_pack_path #(
    parameter int DIG_W = 4,
    parameter int NDIG  = 2,
    localparam int BYTE_W = 2 * DIG_W,
    localparam int WORD_W = NDIG * BYTE_W,
    localparam int PACK_W = NDIG * DIG_W
) (
    input  logic [WORD_W-1:0] loose_i,
    input  logic [WORD_W-1:0] adj_i,
    output logic [PACK_W-1:0] dense_o
);

    logic [WORD_W-1:0] biased;
    logic [WORD_W-1:0] sum_unused_hi;

    // Wrapping add: carry out of the top bit is discarded
    assign biased = loose_i + adj_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign dense_o[g*DIG_W +: DIG_W] = biased[g*BYTE_W +: DIG_W];
    end

    assign sum_unused_hi = biased;

endmodule

// File: rtl/bcd_unpack_path.sv
// Loose path: spread each nibble into its own byte, then bias the word.
module bcd_unpack_path #(
    parameter int DIG_W = 4,
    parameter int NDIG  = 2,
    localparam int BYTE_W = 2 * DIG_W,
    localparam int WORD_W = NDIG * BYTE_W,
    localparam int PACK_W = NDIG * DIG_W
) (
    input  logic [PACK_W-1:0] dense_i,
    input  logic [WORD_W-1:0] adj_i,
    output logic [WORD_W-1:0] loose_o
);

    logic [WORD_W-1:0] spread;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign spread[g*BYTE_W +: DIG_W]              = dense_i[g*DIG_W +: DIG_W];
        assign spread[g*BYTE_W+DIG_W +: BYTE_W-DIG_W] = '0;
    end

    // Wrapping add after spreading
    assign loose_o = spread + adj_i;

endmodule

// File: rtl/bcd_xlate.sv
module bcd_xlate #(
    parameter int DATA_W = 32,
    parameter int DIG_W  = 4,
    parameter int NDIG   = 2,
    localparam int BYTE_W = 2 * DIG_W,
    localparam int WORD_W = NDIG * BYTE_W,
    localparam int PACK_W = NDIG * DIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [WORD_W-1:0] adj_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);

    import bcd_xlate_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              done;
    } xl_state_t;

    xl_state_t st_d, st_q;

    logic [PACK_W-1:0] dense_val;
    logic [WORD_W-1:0] loose_val;
    logic              unused_src_hi;

    assign unused_src_hi = ^src_i[DATA_W-1:WORD_W];

    bcd_pack_path #(
        .DIG_W (DIG_W),
        .NDIG  (NDIG)
    ) u_pack (
        .loose_i (src_i[WORD_W-1:0]),
        .adj_i   (adj_i),
        .dense_o (dense_val)
    );

    bcd_unpack_path #(
        .DIG_W (DIG_W),
        .NDIG  (NDIG)
    ) u_unpack (
        .dense_i (src_i[PACK_W-1:0]),
        .adj_i   (adj_i),
        .loose_o (loose_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done   = 1'b1;
            st_d.result = dst_i;
            if (xl_mode_e'(mode_i) == XL_PACK) begin
                st_d.result[PACK_W-1:0] = dense_val;
            end else begin
                st_d.result[WORD_W-1:0] = loose_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign done_o   = st_q.done;

endmodule

// File: rtl/bcd_xlate_chk.sv
module bcd_xlate_chk #(
    parameter int DATA_W = 32,
    parameter int PACK_W = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mode_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] result_o,
    input logic              done_o
);

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    // R5
    pack_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i) |=> (result_o[DATA_W-1:PACK_W] == $past(dst_i[DATA_W-1:PACK_W])));

    // R7
    unpack_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i) |=> (result_o[DATA_W-1:WORD_W] == $past(dst_i[DATA_W-1:WORD_W])));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !done_o));

endmodule

bind bcd_xlate bcd_xlate_chk #(
    .DATA_W (DATA_W),
    .PACK_W (PACK_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .dst_i    (dst_i),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/bcd_xlate_bench.sv
module bcd_xlate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [15:0] adj_i = '0;
    logic [31:0] result_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit model_on = 0;

    logic [31:0] exp_res;
    logic        exp_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_xlate u_bcd_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .src_i    (src_i),
        .dst_i    (dst_i),
        .adj_i    (adj_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    // Behavioural reference: pack (R4, R8, R10)
    function automatic logic [31:0] ref_pack(input logic [31:0] s, input logic [31:0] d,
                                             input logic [15:0] a);
        int sum, hi, lo;
        sum = ((s % 65536) + a) % 65536;
        hi  = (sum / 256) % 16;
        lo  = sum % 16;
        return (d & 32'hFFFF_FF00) | 32'(hi * 16 + lo);
    endfunction

    // Behavioural reference: unpack (R6, R8, R11)
    function automatic logic [31:0] ref_unpack(input logic [31:0] s, input logic [31:0] d,
                                               input logic [15:0] a);
        int b, word;
        b    = s % 256;
        word = (b / 16) * 256 + (b % 16);
        word = (word + a) % 65536;
        return (d & 32'hFFFF_0000) | 32'(word);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_res  <= '0;
            exp_done <= 1'b0;
        end else begin
            exp_done <= start_i;
            if (start_i)
                exp_res <= mode_i ? ref_unpack(src_i, dst_i, adj_i)
                                  : ref_pack(src_i, dst_i, adj_i);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2, R3 and the data paths)
    always @(negedge clk) begin
        if (model_on && rst_n && !finished) begin
            check("R2 done vs model", {31'b0, done_o}, {31'b0, exp_done});
            check("R3 result vs model", result_o, exp_res);
        end
    end

    task automatic op(input logic m, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; src_i = s; dst_i = d; adj_i = a;
        @(negedge clk);
        check(tag, result_o, exp);
        check("R2 done after start", {31'b0, done_o}, 32'd1);
        start_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 result in reset", result_o, 32'h0);
        check("R1 done in reset", {31'b0, done_o}, 32'h0);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        check("R1 result after reset", result_o, 32'h0);
        check("R1 done after reset", {31'b0, done_o}, 32'h0);

        op(1'b0, 32'h0000_3736, 32'hDEAD_BEEF, 16'h0000, 32'hDEAD_BE76, "R4 R5 pack plain");
        op(1'b0, 32'h0000_3736, 32'h0000_0000, 16'h0102, 32'h0000_0088, "R4 pack with bias");
        op(1'b0, 32'hABCD_3736, 32'h1122_3344, 16'h0000, 32'h1122_3376, "R10 pack upper src ignored");
        op(1'b1, 32'h0000_0076, 32'hCAFE_0000, 16'h3030, 32'hCAFE_3736, "R6 R7 unpack ascii");
        op(1'b1, 32'h1234_5676, 32'h0000_0000, 16'h3030, 32'h0000_3736, "R11 unpack upper src ignored");
        op(1'b1, 32'h0000_0099, 32'h5555_0000, 16'hF7F7, 32'h5555_0100, "R8 unpack wrap");
        op(1'b0, 32'h0000_FFFF, 32'h0000_00AA, 16'h0001, 32'h0000_0000, "R8 pack wrap");
        op(1'b0, 32'h0000_0F0E, 32'h0000_0000, 16'h0000, 32'h0000_00FE, "R9 pack high nibbles");
        op(1'b1, 32'h0000_00BC, 32'hFFFF_FFFF, 16'h0000, 32'hFFFF_0B0C, "R9 unpack high nibbles");
        op(1'b0, 32'h0000_3939, 32'h0000_0000, 16'h0001, 32'h0000_009A, "R9 pack no decimal fix");

        // R3: hold while start is low and inputs move
        held = result_o;
        @(negedge clk);
        check("R2 done low after pulse", {31'b0, done_o}, 32'h0);
        mode_i = 1'b1; src_i = 32'h1357_9BDF; dst_i = 32'h2468_ACE0; adj_i = 16'h7777;
        repeat (4) @(negedge clk);
        check("R3 result held", result_o, held);

        // R2: back-to-back starts
        start_i = 1'b1; mode_i = 1'b0; src_i = 32'h0000_3132; dst_i = '0; adj_i = '0;
        @(negedge clk);
        check("R2 first back-to-back", result_o, 32'h0000_0012);
        mode_i = 1'b1; src_i = 32'h0000_0045;
        @(negedge clk);
        check("R2 second back-to-back", result_o, 32'h0000_0405);
        check("R2 done held high", {31'b0, done_o}, 32'd1);
        start_i = 1'b0;

        // Mixed random traffic, compared by the per-cycle model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            start_i = ($urandom_range(0, 2) != 0);
            mode_i  = $urandom_range(0, 1);
            src_i   = $urandom;
            dst_i   = $urandom;
            adj_i   = 16'($urandom);
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule